// File: doc/BRIEF.md
# Rate Ratio Filter Selector

This block sits beside the arithmetic core of an asynchronous audio sample rate converter. It watches two word clocks: the one that paces incoming samples and the one that paces outgoing samples. It also watches a fast system clock. The block counts system-clock cycles between rising edges of each word clock. From the two periods it finds the output-to-input rate ratio, then drives a 2-bit code that tells the filter core which of four anti-aliasing characteristics to load.

The ratio is never divided. The input period is scaled by 200, the output period is scaled by a band threshold, and the two products are compared. Thresholds of 192, 165 and 140 give band edges at 0.96, 0.825 and 0.70.

Each completed input-clock period gives one classification. A new code takes effect only once the same band has won three classifications in a row. If either word clock has no rising edge for 4096 system clocks, the block raises an unlock flag. It then drops the valid flag and freezes the code until measurements resume.

Top module: `rate_band_sel`

## Requirements
- R1: While reset is low, the outputs read filt_code = 2'b00, code_valid = 0, unlock = 0 and up_conv = 0.
- R2: Each word clock's period is the number of system-clock cycles between two of its rising edges. When Tin·200 ≥ Tout·192 (ratio fso/fsi ≥ 0.96, which covers up-conversion up to 2.0 and beyond), the confirmed code is 2'b00.
- R3: When Tout·165 ≤ Tin·200 < Tout·192 (0.825 ≤ ratio < 0.96, the band around 0.92), the confirmed code is 2'b01.
- R4: When Tout·140 ≤ Tin·200 < Tout·165 (0.70 ≤ ratio < 0.825, the band around 0.73), the confirmed code is 2'b10.
- R5: When Tin·200 < Tout·140 (ratio < 0.70, the band around 0.67), the confirmed code is 2'b11.
- R6: A classification is taken at each completed input period. The code changes only after three consecutive classifications agree on the new band. It never changes while code_valid is low.
- R7: If either word clock shows no rising edge for 4096 system clocks, unlock rises. While unlock is high, code_valid is low and filt_code keeps its last value.
- R8: After a silent clock returns, unlock falls on its next rising edge. code_valid stays low until three fresh classifications agree, and it never rises while unlock is high.
- R9: up_conv is high exactly when code_valid is high and filt_code is 2'b00.
- R10: code_valid rises once the first band has been confirmed after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that counts the periods |
| rst_n | input | 1 | Active-low asynchronous reset |
| wclk_in | input | 1 | Input-side word clock (asynchronous) |
| wclk_out | input | 1 | Output-side word clock (asynchronous) |
| filt_code | output | 2 | Selected filter: 00 up, 01 ≈0.92, 10 ≈0.73, 11 ≈0.67 |
| code_valid | output | 1 | The code has been confirmed and measurement is live |
| up_conv | output | 1 | The confirmed band is the up-conversion band |
| unlock | output | 1 | One of the word clocks has gone silent |

## Verification
The bound checker watches four things on every cycle:
- The code never moves while it is not valid.
- The code stays frozen and invalid during unlock.
- A silence on either port longer than the timeout always shows up as unlock.
- Validity never returns while unlock is high.

The band boundaries, the three-sample confirmation delay, the relock sequence and the up-conversion flag depend on the periods. Only the bench shows them. It sweeps period pairs across all four bands, places the exact threshold equalities on both sides, and stops each word clock in turn.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    typedef enum logic [1:0] {
        BAND_UP  = 2'b00,
        BAND_DN1 = 2'b01,
        BAND_DN2 = 2'b10,
        BAND_DN3 = 2'b11
    } band_e;

endpackage

// File: rtl/rbs_period_meter.sv
module rbs_period_meter #(
    parameter int TIMEOUT = 4096,
    parameter int CNT_W   = $clog2(TIMEOUT) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk,
    output logic [CNT_W-1:0] period_o,
    output logic             meas_o,
    output logic             ok_o,
    output logic             stale_o,
    output logic             stale_d_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
        logic             primed;
        logic             ok;
        logic             meas;
        logic             stale;
    } meter_t;

    meter_t st_d, st_q;
    logic   rise;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], wclk};
        st_d.prev = st_q.sync[1];
        st_d.meas = 1'b0;
        rise      = st_q.sync[1] & ~st_q.prev;
        if (rise) begin
            st_d.cnt    = '0;
            st_d.stale  = 1'b0;
            st_d.primed = 1'b1;
            if (st_q.primed) begin
                st_d.period = st_q.cnt + 1'b1;
                st_d.meas   = 1'b1;
                st_d.ok     = 1'b1;
            end
        end else if (st_q.cnt >= LIMIT) begin
            st_d.stale  = 1'b1;
            st_d.primed = 1'b0;
            st_d.ok     = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign period_o  = st_q.period;
    assign meas_o    = st_q.meas;
    assign ok_o      = st_q.ok;
    assign stale_o   = st_q.stale;
    assign stale_d_o = st_d.stale;

endmodule

// File: rtl/rbs_ratio_bands.sv
module rbs_ratio_bands
    import rbs_pkg::*;
#(
    parameter int CNT_W = 13,
    parameter int K_REF = 200,
    parameter int K_UP  = 192,
    parameter int K_D1  = 165,
    parameter int K_D2  = 140
) (
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] per_out,
    output band_e            band_o
);

    localparam int PW = CNT_W + 9;

    logic [PW-1:0] scaled_in;
    logic [PW-1:0] lim_up, lim_d1, lim_d2;

    always_comb begin
        scaled_in = PW'(per_in)  * PW'(K_REF);
        lim_up    = PW'(per_out) * PW'(K_UP);
        lim_d1    = PW'(per_out) * PW'(K_D1);
        lim_d2    = PW'(per_out) * PW'(K_D2);
        if (scaled_in >= lim_up)      band_o = BAND_UP;
        else if (scaled_in >= lim_d1) band_o = BAND_DN1;
        else if (scaled_in >= lim_d2) band_o = BAND_DN2;
        else                          band_o = BAND_DN3;
    end

endmodule

// File: rtl/rbs_band_confirm.sv
module rbs_band_confirm
    import rbs_pkg::*;
#(
    parameter int CONFIRM = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sample_i,
    input  band_e band_i,
    input  logic  hold_i,
    output band_e code_o,
    output logic  valid_o
);

    localparam int RW = $clog2(CONFIRM + 1);
    localparam logic [RW-1:0] FULL = RW'(CONFIRM);

    typedef struct packed {
        band_e         cand;
        logic [RW-1:0] run;
        band_e         code;
        logic          valid;
    } conf_t;

    conf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.run   = '0;
            st_d.valid = 1'b0;
        end else if (sample_i) begin
            if (band_i == st_q.cand && st_q.run != '0) begin
                st_d.run = (st_q.run == FULL) ? FULL : st_q.run + 1'b1;
            end else begin
                st_d.cand = band_i;
                st_d.run  = RW'(1);
            end
            if (st_d.run == FULL) begin
                st_d.code  = st_d.cand;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cand: BAND_UP, run: '0, code: BAND_UP, valid: 1'b0};
        else        st_q <= st_d;
    end

    assign code_o  = st_q.code;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/rate_band_sel.sv
module rate_band_sel
    import rbs_pkg::*;
#(
    parameter int TIMEOUT = 4096,
    parameter int CONFIRM = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wclk_in,
    input  logic       wclk_out,
    output logic [1:0] filt_code,
    output logic       code_valid,
    output logic       up_conv,
    output logic       unlock
);

    localparam int CNT_W = $clog2(TIMEOUT) + 1;

    typedef struct packed {
        logic unlock;
    } top_t;

    top_t st_d, st_q;

    logic [CNT_W-1:0] per_in, per_out;
    logic             meas_in, meas_out;
    logic             ok_in, ok_out;
    logic             stale_in, stale_out;
    logic             stale_in_d, stale_out_d;
    logic             sample;
    band_e            band_now, code_q;
    logic             valid_q;

    rbs_period_meter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) meter_in_i (
        .clk(clk), .rst_n(rst_n), .wclk(wclk_in),
        .period_o(per_in), .meas_o(meas_in), .ok_o(ok_in),
        .stale_o(stale_in), .stale_d_o(stale_in_d)
    );

    rbs_period_meter #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) meter_out_i (
        .clk(clk), .rst_n(rst_n), .wclk(wclk_out),
        .period_o(per_out), .meas_o(meas_out), .ok_o(ok_out),
        .stale_o(stale_out), .stale_d_o(stale_out_d)
    );

    rbs_ratio_bands #(.CNT_W(CNT_W)) bands_i (
        .per_in(per_in), .per_out(per_out), .band_o(band_now)
    );

    rbs_band_confirm #(.CONFIRM(CONFIRM)) confirm_i (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .band_i(band_now),
        .hold_i(st_d.unlock), .code_o(code_q), .valid_o(valid_q)
    );

    always_comb begin
        st_d        = st_q;
        st_d.unlock = stale_in_d | stale_out_d;
        sample      = meas_in & ok_in & ok_out & ~stale_out & ~st_q.unlock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_code  = code_q;
    assign code_valid = valid_q;
    assign up_conv    = valid_q & (code_q == BAND_UP);
    assign unlock     = st_q.unlock;

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
    parameter int TIMEOUT = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wclk_in,
    input logic       wclk_out,
    input logic [1:0] filt_code,
    input logic       code_valid,
    input logic       up_conv,
    input logic       unlock
);

    localparam int GW = $clog2(TIMEOUT + 16) + 1;
    localparam logic [GW-1:0] GAP_MAX = GW'(TIMEOUT + 8);

    logic          in_prev, out_prev;
    logic [GW-1:0] gap_in, gap_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_prev  <= 1'b0;
            out_prev <= 1'b0;
            gap_in   <= '0;
            gap_out  <= '0;
        end else begin
            in_prev  <= wclk_in;
            out_prev <= wclk_out;
            gap_in   <= (wclk_in  & ~in_prev)  ? '0 : (gap_in  > GAP_MAX) ? gap_in  : gap_in  + 1'b1;
            gap_out  <= (wclk_out & ~out_prev) ? '0 : (gap_out > GAP_MAX) ? gap_out : gap_out + 1'b1;
        end
    end

    AST_CODE_MOVES_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_code) |-> code_valid); // R6

    AST_UNLOCK_BLANKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |-> !code_valid); // R7

    AST_CODE_FROZEN_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock && $past(unlock)) |-> $stable(filt_code)); // R7

    AST_SILENCE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_in > GAP_MAX || gap_out > GAP_MAX) |-> unlock); // R7

    AST_VALID_RISES_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> !unlock); // R8

endmodule

bind rate_band_sel rbs_checker #(.TIMEOUT(TIMEOUT)) chk_i (
    .clk(clk), .rst_n(rst_n), .wclk_in(wclk_in), .wclk_out(wclk_out),
    .filt_code(filt_code), .code_valid(code_valid), .up_conv(up_conv), .unlock(unlock)
);

// File: tb/rate_band_sel_tb.sv
module rate_band_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wclk_in = 1'b0;
    logic       wclk_out = 1'b0;
    logic [1:0] filt_code;
    logic       code_valid;
    logic       up_conv;
    logic       unlock;

    int checks = 0;
    int failures = 0;
    int tin_p = 60;
    int tout_p = 60;
    bit en_in = 1'b1;
    bit en_out = 1'b1;
    int ci = 0;
    int co = 0;

    always #2 clk = ~clk;

    rate_band_sel dut_i (
        .clk(clk), .rst_n(rst_n), .wclk_in(wclk_in), .wclk_out(wclk_out),
        .filt_code(filt_code), .code_valid(code_valid), .up_conv(up_conv), .unlock(unlock)
    );

    always @(negedge clk) begin
        if (en_in) begin
            ci = (ci + 1 >= tin_p) ? 0 : ci + 1;
            wclk_in = (ci < tin_p / 2);
        end
        if (en_out) begin
            co = (co + 1 >= tout_p) ? 0 : co + 1;
            wclk_out = (co < tout_p / 2);
        end
    end

    function automatic int exp_band(int ti, int to);
        if (ti * 200 >= to * 192)      return 0;
        else if (ti * 200 >= to * 165) return 1;
        else if (ti * 200 >= to * 140) return 2;
        else                           return 3;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d (tin=%0d tout=%0d)", req, act, exp, tin_p, tout_p);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic settle_and_check(int ti, int to);
        int e;
        string tag;
        tin_p = ti;
        tout_p = to;
        cycles(10 * ((ti > to) ? ti : to) + 40);
        e = exp_band(ti, to);
        tag = (e == 0) ? "R2" : (e == 1) ? "R3" : (e == 2) ? "R4" : "R5";
        check(tag, filt_code, e);
        check("R10 valid", code_valid, 1);
        check("R9 up_conv", up_conv, (e == 0) ? 1 : 0);
    endtask

    initial begin
        #(4 * 190000);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cycles(10);
        check("R1 code", filt_code, 0);
        check("R1 valid", code_valid, 0);
        check("R1 unlock", unlock, 0);
        check("R1 up_conv", up_conv, 0);
        rst_n = 1'b1;

        settle_and_check(60, 60);

        for (int to = 30; to <= 130; to += 2) settle_and_check(60, to);
        for (int ti = 60; ti <= 110; ti += 5) settle_and_check(ti, 100);

        settle_and_check(147, 160);
        settle_and_check(320, 441);
        settle_and_check(200, 300);

        settle_and_check(96, 100);
        settle_and_check(95, 100);
        settle_and_check(66, 80);
        settle_and_check(65, 80);
        settle_and_check(70, 100);
        settle_and_check(69, 100);

        // R6: a band change needs three agreeing classifications
        settle_and_check(60, 60);
        tout_p = 80;
        cycles(100);
        check("R6 held", filt_code, 0);
        cycles(1000);
        check("R6 moved R4", filt_code, 2);

        // R7: output word clock goes silent
        settle_and_check(66, 80);
        en_out = 1'b0;
        cycles(3900);
        check("R7 not early", unlock, 0);
        cycles(300);
        check("R7 unlock", unlock, 1);
        check("R7 valid low", code_valid, 0);
        check("R7 code held", filt_code, 1);
        check("R9 up low", up_conv, 0);

        // R8: relock with a new ratio
        tin_p = 60;
        tout_p = 60;
        en_out = 1'b1;
        cycles(100);
        check("R8 unlock clear", unlock, 0);
        check("R8 valid waits", code_valid, 0);
        check("R8 code still held", filt_code, 1);
        cycles(1000);
        check("R8 valid back", code_valid, 1);
        check("R8 new code", filt_code, 0);

        // R7: input word clock goes silent
        en_in = 1'b0;
        cycles(4300);
        check("R7 unlock in", unlock, 1);
        check("R7 code held in", filt_code, 0);
        en_in = 1'b1;
        cycles(1000);
        check("R8 relock in", unlock, 0);
        check("R8 valid in", code_valid, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule